// File: doc/BRIEF.md
# E1 CRC-4 Generator and Checker

This block protects an E1 bit stream with a 4-bit cyclic check in both directions. Each 16-frame multiframe is split into two halves of eight frames. A half is one check block. On the transmit path, the block divides every half by x^4 + x + 1. It then writes the four remainder bits into the first bit of timeslot 0 of the odd frames of the same half in the following multiframe. All other bits pass through unchanged.

On the receive path, the same division runs on the incoming stream. The block gathers the four check bits that arrive one multiframe later and compares them with the locally stored remainder. A mismatch gives a one-cycle error pulse and advances a saturating counter.

Both directions are serial, one bit per accepted beat. Each beat carries its frame number (0 to 15) and its bit position within the frame (0 to FRAME_BITS-1). An upstream aligner supplies these positions, and on the receive side it also supplies a multiframe-lock level.

The transmit path is a valid/ready pass-through stage with no storage. `tx_s_ready` equals `tx_m_ready`, and `tx_m_valid` equals `tx_s_valid`. A transmit beat is consumed only when valid and ready are both high. While the downstream side stalls, the input beat must be held, and no internal state moves.

The receive path never applies back-pressure: `rx_ready` is always high, and every cycle with `rx_valid` high consumes one bit.

Top module: `e1crc_codec`

## Requirements
- R1: The remainder of a block is the 4-bit remainder of (block bits · x^4) divided by x^4 + x + 1. The block bits are taken in stream order, first bit as the highest power. The division restarts at frame 0 bit 0 and at frame 8 bit 0. Each check-bit position (bit 0 of an odd frame) counts as 0.
- R2: The transmit output carries the remainder of the previous multiframe's block in bit 0 of the odd frames of the same half. Frames 1, 3, 5 and 7 carry remainder bits 3, 2, 1, 0 of the first half. Frames 9, 11, 13 and 15 carry those bits of the second half.
- R3: On the transmit path, every bit that is not a check-bit position leaves unchanged. The value presented at a check-bit position is discarded.
- R4: `tx_s_ready` follows `tx_m_ready`, and `tx_m_valid` follows `tx_s_valid`. A beat without both valid and ready alters neither the stored remainders nor the division in progress.
- R5: On the receive path, the four bits found at the check positions of a half are compared with the remainder computed over the same half one multiframe earlier. A mismatch drives `crc_error` high for exactly one cycle. That cycle directly follows the acceptance of the fourth check bit (frame 7 or frame 15, bit 0).
- R6: No comparison is reported until `rx_sync` has stayed high across two accepted multiframe ends (frame 15, last bit). A low `rx_sync` restarts this count.
- R7: `err_count` increments by one for each `crc_error` pulse. It holds at 2^CNT_W - 1 once it reaches that value.
- R8: After reset, `crc_error` and `err_count` are 0. Both stored remainders are 0, so the transmit side inserts 0 bits until a first block has completed.
- R9: `rx_ready` is held high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_s_valid | input | 1 | Transmit input beat valid |
| tx_s_ready | output | 1 | Transmit input may advance |
| tx_s_data | input | 1 | Transmit input bit |
| tx_s_frame | input | 4 | Frame number of the transmit beat |
| tx_s_bit | input | $clog2(FRAME_BITS) | Bit position of the transmit beat within its frame |
| tx_m_valid | output | 1 | Transmit output beat valid |
| tx_m_ready | input | 1 | Downstream accepts the transmit output |
| tx_m_data | output | 1 | Transmit output bit with check bits inserted |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Receive side accepts (always high) |
| rx_data | input | 1 | Receive bit |
| rx_frame | input | 4 | Frame number of the receive beat |
| rx_bit | input | $clog2(FRAME_BITS) | Bit position of the receive beat within its frame |
| rx_sync | input | 1 | Multiframe lock from the aligner |
| crc_error | output | 1 | One-cycle pulse on a block mismatch |
| err_count | output | CNT_W | Saturating count of mismatches |

## Verification
The bench builds the block with FRAME_BITS = 32 and CNT_W = 3. A 32-bit frame cuts a multiframe to 512 beats, so runs of ten multiframes stay short. They still cover the arming delay, a lock drop and the re-arming after it. A 3-bit counter saturates at 7, so more than seven mismatches drive it into its hold state within a single test. The framing logic is unchanged by these values; only the counts of bits per frame and of errors shrink.

// File: rtl/e1crc_pkg.sv
package e1crc_pkg;

  localparam int unsigned FRM_W     = 4;   // 16 frames per multiframe
  localparam int unsigned BLK_FRAME = 8;   // frames per check block

  typedef logic [3:0] crc4_t;

  // decoded position of one beat
  typedef struct packed {
    logic       blk;        // 0: frames 0-7, 1: frames 8-15
    logic [1:0] chk_idx;    // which odd frame of the half (0..3)
    logic       chk_pos;    // bit 0 of an odd frame
    logic       blk_start;  // first bit of a half
    logic       blk_end;    // last bit of a half
    logic       last_chk;   // fourth check bit of a half
    logic       mf_end;     // last bit of the multiframe
  } pos_t;

  // one step of serial division by x^4 + x + 1
  function automatic crc4_t crc4_step(crc4_t c, logic d);
    logic fb;
    fb = d ^ c[3];
    return {c[2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
  endfunction

endpackage

// File: rtl/e1crc_pos_decode.sv
module e1crc_pos_decode
  import e1crc_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256,
  localparam int unsigned BIT_W = $clog2(FRAME_BITS)
) (
  input  logic [FRM_W-1:0] frame,
  input  logic [BIT_W-1:0] bitpos,
  output pos_t             pos
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

  logic [2:0] fin;
  logic       first_bit;
  logic       last_bit;

  assign fin       = frame[2:0];
  assign first_bit = (bitpos == '0);
  assign last_bit  = (bitpos == LAST_BIT);

  always_comb begin
    pos.blk       = frame[3];
    pos.chk_idx   = fin[2:1];
    pos.chk_pos   = first_bit && fin[0];
    pos.blk_start = first_bit && (fin == 3'd0);
    pos.blk_end   = last_bit  && (fin == 3'd7);
    pos.last_chk  = first_bit && (fin == 3'd7);
    pos.mf_end    = last_bit  && (frame == 4'd15);
  end

endmodule

// File: rtl/e1crc_engine.sv
module e1crc_engine
  import e1crc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            d,
  input  pos_t            pos,
  output logic [1:0][3:0] stored
);

  crc4_t state;
  crc4_t base;
  crc4_t nxt;
  logic  d_eff;

  assign d_eff = pos.chk_pos ? 1'b0 : d;
  assign base  = pos.blk_start ? 4'b0000 : state;
  assign nxt   = crc4_step(base, d_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= '0;
      stored <= '0;
    end else if (fire) begin
      state <= nxt;
      if (pos.blk_end) stored[pos.blk] <= nxt;
    end
  end

  // division restarts from zero at a block start
  assert_block_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && pos.blk_start |=> state == ($past(d_eff) ? 4'b0011 : 4'b0000));

  // the closing remainder is kept for the half that just ended
  assert_block_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && pos.blk_end |=> stored[$past(pos.blk)] == state);

  // a beat that is not taken leaves the stored remainders alone
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(stored) && $stable(state));

endmodule

// File: rtl/e1crc_rx_check.sv
module e1crc_rx_check
  import e1crc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             d,
  input  logic             sync,
  input  pos_t             pos,
  input  logic [1:0][3:0]  stored,
  output logic             crc_error,
  output logic [CNT_W-1:0] err_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [1:0][2:0] got;
  logic [1:0]      mf_seen;
  logic            armed;
  crc4_t           rx_word;

  assign armed   = (mf_seen == 2'd2);
  assign rx_word = {got[pos.blk], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got       <= '0;
      mf_seen   <= '0;
      crc_error <= 1'b0;
    end else begin
      crc_error <= fire && pos.last_chk && armed && (rx_word != stored[pos.blk]);
      if (fire && pos.chk_pos) got[pos.blk] <= {got[pos.blk][1:0], d};
      if (!sync)                                     mf_seen <= '0;
      else if (fire && pos.mf_end && !armed)          mf_seen <= mf_seen + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               err_count <= '0;
    else if (crc_error && err_count != CNT_MAX) err_count <= err_count + 1'b1;
  end

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    crc_error |=> !crc_error);

  assert_only_when_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    crc_error |-> $past(armed && fire && sync));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    crc_error && err_count != CNT_MAX |=> err_count == $past(err_count) + 1'b1);

  assert_count_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_count == CNT_MAX |=> err_count == CNT_MAX);

  assert_count_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_error |=> $stable(err_count));

endmodule

// File: rtl/e1crc_codec.sv
module e1crc_codec
  import e1crc_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned BIT_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_s_valid,
  output logic             tx_s_ready,
  input  logic             tx_s_data,
  input  logic [3:0]       tx_s_frame,
  input  logic [BIT_W-1:0] tx_s_bit,
  output logic             tx_m_valid,
  input  logic             tx_m_ready,
  output logic             tx_m_data,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic             rx_data,
  input  logic [3:0]       rx_frame,
  input  logic [BIT_W-1:0] rx_bit,
  input  logic             rx_sync,
  output logic             crc_error,
  output logic [CNT_W-1:0] err_count
);

  pos_t            tx_pos;
  pos_t            rx_pos;
  logic [1:0][3:0] tx_stored;
  logic [1:0][3:0] rx_stored;
  logic            tx_fire;
  logic            rx_fire;
  logic            ins_bit;

  // ---------------- transmit path ----------------
  assign tx_s_ready = tx_m_ready;
  assign tx_m_valid = tx_s_valid;
  assign tx_fire    = tx_s_valid && tx_m_ready;

  e1crc_pos_decode #(.FRAME_BITS(FRAME_BITS)) u_tx_pos (
    .frame (tx_s_frame),
    .bitpos(tx_s_bit),
    .pos   (tx_pos)
  );

  e1crc_engine u_tx_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (tx_fire),
    .d     (tx_s_data),
    .pos   (tx_pos),
    .stored(tx_stored)
  );

  // frame 1/9 carries bit 3, frame 7/15 carries bit 0
  assign ins_bit   = tx_stored[tx_pos.blk][~tx_pos.chk_idx];
  assign tx_m_data = tx_pos.chk_pos ? ins_bit : tx_s_data;

  assert_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_s_valid && !tx_pos.chk_pos |-> tx_m_data == tx_s_data);

  // ---------------- receive path ----------------
  assign rx_ready = 1'b1;
  assign rx_fire  = rx_valid;

  e1crc_pos_decode #(.FRAME_BITS(FRAME_BITS)) u_rx_pos (
    .frame (rx_frame),
    .bitpos(rx_bit),
    .pos   (rx_pos)
  );

  e1crc_engine u_rx_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (rx_fire),
    .d     (rx_data),
    .pos   (rx_pos),
    .stored(rx_stored)
  );

  e1crc_rx_check #(.CNT_W(CNT_W)) u_rx_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (rx_fire),
    .d        (rx_data),
    .sync     (rx_sync),
    .pos      (rx_pos),
    .stored   (rx_stored),
    .crc_error(crc_error),
    .err_count(err_count)
  );

endmodule

// File: tb/tb_e1crc_codec.sv
module tb_e1crc_codec;

  localparam int FB    = 32;
  localparam int CW    = 3;
  localparam int BW    = $clog2(FB);
  localparam int MFB   = 16 * FB;
  localparam int NMAX  = 10;
  localparam int BLKB  = 8 * FB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_s_valid = 1'b0;
  logic          tx_s_ready;
  logic          tx_s_data = 1'b0;
  logic [3:0]    tx_s_frame = '0;
  logic [BW-1:0] tx_s_bit = '0;
  logic          tx_m_valid;
  logic          tx_m_ready = 1'b1;
  logic          tx_m_data;
  logic          rx_valid = 1'b0;
  logic          rx_ready;
  logic          rx_data = 1'b0;
  logic [3:0]    rx_frame = '0;
  logic [BW-1:0] rx_bit = '0;
  logic          rx_sync = 1'b0;
  logic          crc_error;
  logic [CW-1:0] err_count;

  int n_checks = 0;
  int n_fail   = 0;

  logic strm  [0:NMAX*MFB-1];
  logic txout [0:NMAX*MFB-1];
  logic cd [0:NMAX-1][0:1];
  logic cc [0:NMAX-1][0:1];
  logic obs [0:NMAX-1][0:1];
  int   unexpected;

  always #2 clk = ~clk;   // 250 MHz

  e1crc_codec #(.FRAME_BITS(FB), .CNT_W(CW)) dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference: long division of (block * x^4) by 10011
  function automatic logic [3:0] ref_crc(int m, int b);
    logic [4:0] r;
    logic v;
    r = '0;
    for (int i = 0; i < BLKB + 4; i++) begin
      if (i >= BLKB) v = 1'b0;
      else begin
        int f; int bt;
        f  = b * 8 + i / FB;
        bt = i % FB;
        v  = (bt == 0 && (f % 2) == 1) ? 1'b0 : strm[m*MFB + f*FB + bt];
      end
      r = {r[3:0], v};
      if (r[4]) r = r ^ 5'b10011;
    end
    return r[3:0];
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; tx_s_valid = 1'b0; rx_valid = 1'b0; rx_sync = 1'b0; tx_m_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic clear_marks();
    for (int m = 0; m < NMAX; m++) for (int b = 0; b < 2; b++) begin
      cd[m][b] = 1'b0; cc[m][b] = 1'b0; obs[m][b] = 1'b0;
    end
    unexpected = 0;
  endtask

  // random data, then correct check bits, then the marked corruptions
  task automatic build(input int nmf);
    for (int g = 0; g < nmf*MFB; g++) strm[g] = 1'($urandom_range(0, 1));
    for (int g = 0; g < MFB; g++) if ((g % FB) == 0 && ((g / FB) % 2) == 1) strm[g] = 1'b0;
    for (int m = 0; m + 1 < nmf; m++) for (int b = 0; b < 2; b++) begin
      logic [3:0] c;
      c = ref_crc(m, b);
      for (int k = 0; k < 4; k++) strm[(m+1)*MFB + (b*8 + 2*k + 1)*FB] = c[3-k];
    end
    for (int m = 0; m < nmf; m++) for (int b = 0; b < 2; b++) begin
      if (cd[m][b]) strm[m*MFB + (b*8+2)*FB + 3] = ~strm[m*MFB + (b*8+2)*FB + 3];
      if (cc[m][b]) strm[m*MFB + (b*8+3)*FB]     = ~strm[m*MFB + (b*8+3)*FB];
    end
  endtask

  task automatic note_pulse(input int g);
    int m; int p; int f; int bt;
    m = g / MFB; p = g % MFB; f = p / FB; bt = p % FB;
    if (bt == 0 && (f % 8) == 7) obs[m][f/8] = 1'b1;
    else unexpected++;
  endtask

  task automatic run_rx(input int m0, input int m1, input int drop_mf);
    int prev;
    prev = -1;
    for (int m = m0; m < m1; m++) begin
      if (m == drop_mf) begin
        @(negedge clk);
        if (prev >= 0 && crc_error) note_pulse(prev);
        prev = -1;
        rx_valid = 1'b0; rx_sync = 1'b0;
        @(negedge clk);
        rx_sync = 1'b1;
      end
      for (int p = 0; p < MFB; p++) begin
        @(negedge clk);
        if (prev >= 0 && crc_error) note_pulse(prev);
        rx_valid = 1'b1;
        rx_data  = strm[m*MFB + p];
        rx_frame = 4'(p / FB);
        rx_bit   = BW'(p % FB);
        prev     = m*MFB + p;
      end
    end
    @(negedge clk);
    if (prev >= 0 && crc_error) note_pulse(prev);
    rx_valid = 1'b0;
  endtask

  function automatic bit is_armed(int m, int drop_mf);
    if (drop_mf < 0) return m >= 2;
    return (m >= 2 && m < drop_mf) || (m >= drop_mf + 2);
  endfunction

  task automatic compare_pulses(input int m0, input int m1, input int drop_mf);
    for (int m = m0; m < m1; m++) for (int b = 0; b < 2; b++) begin
      bit e;
      e = is_armed(m, drop_mf) && m >= 1 && (cd[m-1][b] || cc[m][b]);
      check(obs[m][b] == e, $sformatf("R5/R6 pulse mf%0d half%0d", m, b), int'(obs[m][b]), int'(e));
    end
    check(unexpected == 0, "R5 pulse at a non-check position", unexpected, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    do_reset();
    check(crc_error == 1'b0, "R8 crc_error after reset", int'(crc_error), 0);
    check(err_count == '0, "R8 err_count after reset", int'(err_count), 0);
    check(rx_ready == 1'b1, "R9 rx_ready", int'(rx_ready), 1);
    tx_m_ready = 1'b0; #1;
    check(tx_s_ready == 1'b0, "R4 ready follows downstream", int'(tx_s_ready), 0);
    tx_s_valid = 1'b1; #1;
    check(tx_m_valid == 1'b1, "R4 valid follows upstream", int'(tx_m_valid), 1);
    tx_s_valid = 1'b0; tx_m_ready = 1'b1;
  endtask

  task automatic t_tx_insert();
    int nt; int bad_pass; int bad_hs;
    nt = 4; bad_pass = 0; bad_hs = 0;
    do_reset();
    clear_marks();
    for (int g = 0; g < nt*MFB; g++) strm[g] = 1'($urandom_range(0, 1));
    for (int g = 0; g < nt*MFB; g++) begin
      int p;
      p = g % MFB;
      if ((g % 7) == 3) begin            // downstream stall with junk on the input
        @(negedge clk);
        tx_s_valid = 1'b1; tx_m_ready = 1'b0; tx_s_data = ~strm[g];
        tx_s_frame = 4'(p / FB); tx_s_bit = BW'(p % FB);
        #1;
        if (tx_s_ready !== 1'b0) bad_hs++;
      end
      if ((g % 11) == 5) begin           // upstream gap with junk on the input
        @(negedge clk);
        tx_s_valid = 1'b0; tx_m_ready = 1'b1; tx_s_data = ~strm[g];
        tx_s_frame = 4'(p / FB); tx_s_bit = BW'(p % FB);
        #1;
        if (tx_m_valid !== 1'b0) bad_hs++;
      end
      @(negedge clk);
      tx_s_valid = 1'b1; tx_m_ready = 1'b1; tx_s_data = strm[g];
      tx_s_frame = 4'(p / FB); tx_s_bit = BW'(p % FB);
      #1;
      txout[g] = tx_m_data;
      if (!((p % FB) == 0 && ((p / FB) % 2) == 1) && tx_m_data !== strm[g]) bad_pass++;
    end
    @(negedge clk);
    tx_s_valid = 1'b0;
    check(bad_pass == 0, "R3 non-check bits unchanged", bad_pass, 0);
    check(bad_hs == 0, "R4 handshake pins", bad_hs, 0);
    for (int m = 0; m < nt; m++) for (int b = 0; b < 2; b++) begin
      logic [3:0] got; logic [3:0] exp;
      for (int k = 0; k < 4; k++) got[3-k] = txout[m*MFB + (b*8 + 2*k + 1)*FB];
      exp = (m == 0) ? 4'b0000 : ref_crc(m - 1, b);
      check(got == exp, $sformatf("%s insert mf%0d half%0d", (m == 0) ? "R8" : "R1/R2", m, b),
            int'(got), int'(exp));
    end
  endtask

  task automatic t_rx_detect();
    do_reset();
    clear_marks();
    cd[0][0] = 1'b1;   // reported in mf1: not yet armed
    cd[1][1] = 1'b1;   // reported in mf2
    cc[3][0] = 1'b1;   // wrong check bit, reported in mf3
    build(5);
    rx_sync = 1'b1;
    run_rx(0, 5, -1);
    compare_pulses(0, 5, -1);
    check(err_count == 3'd2, "R7 count after two mismatches", int'(err_count), 2);
  endtask

  task automatic t_rx_saturate();
    do_reset();
    clear_marks();
    for (int m = 0; m < 9; m++) begin cd[m][0] = 1'b1; cd[m][1] = 1'b1; end
    build(10);
    rx_sync = 1'b1;
    run_rx(0, 4, -1);
    check(err_count == 3'd4, "R7 count after four mismatches", int'(err_count), 4);
    run_rx(4, 10, -1);
    compare_pulses(0, 10, -1);
    check(err_count == 3'd7, "R7 saturated count", int'(err_count), 7);
  endtask

  task automatic t_rx_resync();
    do_reset();
    clear_marks();
    cd[3][0] = 1'b1; cd[3][1] = 1'b1;   // would show in mf4: suppressed
    cd[4][0] = 1'b1; cd[4][1] = 1'b1;   // shows in mf5
    build(6);
    rx_sync = 1'b1;
    run_rx(0, 6, 3);
    compare_pulses(0, 6, 3);
    check(err_count == 3'd2, "R6 count after lock drop", int'(err_count), 2);
  endtask

  initial begin
    t_reset();
    t_tx_insert();
    t_rx_detect();
    t_rx_saturate();
    t_rx_resync();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule